// File: doc/BRIEF.md
# Ping-Pong Channel Capture Buffer

This block stores captured event samples for one acquisition channel in two small FIFOs that take turns. One FIFO, the write bank, accepts new 20-bit event payloads (coarse time, fine time, ADC value). The other FIFO, the read bank, is drained by the readout side. A free-running role counter advances on a slow tick strobe, and its top bit decides which FIFO is the read bank. The two banks therefore swap roles at a fixed period, and neither bank is ever readable and writable at the same time.

The readout side names the bank it wants on every read. The block never stalls the reader. Each read returns a 23-bit word one cycle later, with a 3-bit status tag in the top bits. The tag says whether the word is normal data, the final entry held in the bank, an empty bank or a bank that is busy being written. Empty and busy words carry a zeroed payload. A write into a full write bank is dropped and raises a sticky overflow flag.

Top module: `pp_capture_buffer`

## Requirements
- R1: While `rst` is high at a clock edge, the following values hold after that edge: both banks empty, `rd_valid` 0, `rd_word` 0, `overflow` 0 and role counter 64. The top counter bit is then 1, so `rd_sel` = 1, bank B is read and bank A is written.
- R2: The output word is laid out with status in bits [22:20], coarse time in [19:14], fine time in [13:10] and ADC in [9:0]. The bank's data comes out in first-in first-out order. Status 3'b000 marks normal data with at least one entry still held behind it.
- R3: The 7-bit role counter advances by one on each clock where `tick` is high and wraps at 128. `rd_sel` equals its top bit, where 0 means bank A is read and 1 means bank B is read. The write bank is always the other bank, so `rd_sel` changes only after a tick.
- R4: A read whose `rd_bank` differs from `rd_sel` targets the write bank. It returns status 3'b100 with a zero payload and removes nothing.
- R5: A read of the read bank while that bank is empty returns status 3'b010 with a zero payload.
- R6: A read that removes the only entry left in the read bank returns status 3'b001 with that entry's data. With no role change in between, the next read of that bank returns 3'b010.
- R7: Each bank holds 10 entries. A write into the write bank while it holds 10 entries is dropped and sets `overflow`. `overflow` stays set until reset.
- R8: `rd_valid` is high exactly in the cycle after a cycle with `rd_en` high. While `rd_valid` is low, `rd_word` is zero.
- R9: Writes go only into the current write bank. Entries kept across a role change stay in order and come out once that bank becomes the read bank.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base strobe that advances the role counter |
| wr_en | input | 1 | Store `wr_event` into the write bank |
| wr_event | input | 20 | Event payload: coarse[19:14], fine[13:10], ADC[9:0] |
| rd_en | input | 1 | Read request |
| rd_bank | input | 1 | Bank requested by the reader (0 = A, 1 = B) |
| rd_valid | output | 1 | Read result valid |
| rd_word | output | 23 | Status-tagged output word |
| rd_sel | output | 1 | Bank currently in read mode (0 = A, 1 = B) |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
Several properties are checked on every cycle: the one-cycle read latency, the zero word when the output is idle, and that only the four legal status codes appear. The checker also confirms that busy and empty words carry no payload, that a read of the write bank is tagged busy, that roles change only after a tick, and that overflow never clears by itself. Other behaviours depend on history and show only through the bench's scenarios. These are the FIFO order of data, the final-entry tag followed by empty, the capacity of ten with the drop on the eleventh write, and data kept across role swaps. The bench's queue model follows them through directed sequences and a long random mix.

// File: rtl/pp_pkg.sv
package pp_pkg;

    localparam int COARSE_W = 6;
    localparam int FINE_W   = 4;
    localparam int ADC_W    = 10;
    localparam int EVENT_W  = COARSE_W + FINE_W + ADC_W;
    localparam int STATUS_W = 3;
    localparam int WORD_W   = STATUS_W + EVENT_W;

    typedef struct packed {
        logic [COARSE_W-1:0] coarse;
        logic [FINE_W-1:0]   fine;
        logic [ADC_W-1:0]    adc;
    } event_t;

    typedef enum logic [STATUS_W-1:0] {
        ST_NORMAL = 3'b000,
        ST_LAST   = 3'b001,
        ST_EMPTY  = 3'b010,
        ST_BUSY   = 3'b100
    } status_e;

    typedef struct packed {
        status_e status;
        event_t  ev;
    } word_t;

    localparam event_t EVENT_ZERO = '{coarse: '0, fine: '0, adc: '0};
    localparam word_t  WORD_ZERO  = '{status: ST_NORMAL, ev: EVENT_ZERO};

    // Status words that report a condition carry no payload.
    function automatic word_t tag_only(status_e st);
        word_t w;
        w.status = st;
        w.ev     = EVENT_ZERO;
        return w;
    endfunction

    function automatic word_t tag_data(status_e st, event_t ev);
        word_t w;
        w.status = st;
        w.ev     = ev;
        return w;
    endfunction

endpackage

// File: rtl/pp_fifo.sv
module pp_fifo
    import pp_pkg::*;
#(
    parameter int DEPTH = 10
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   push,
    input  event_t din,
    input  logic   pop,
    output event_t head,
    output logic   full,
    output logic   empty,
    output logic   last
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    event_t           mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] level;
    logic             do_push;
    logic             do_pop;

    assign full    = (level == CNT_MAX);
    assign empty   = (level == '0);
    assign last    = (level == CNT_ONE);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == PTR_MAX) ? '0 : wr_ptr + 1'b1;
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == PTR_MAX) ? '0 : rd_ptr + 1'b1;
            end
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

endmodule

// File: rtl/pp_role_timer.sv
module pp_role_timer #(
    parameter int CNT_W = 7
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    output logic read_sel
);
    // Reset value puts the top bit at 1 so bank A starts as the write bank.
    localparam logic [CNT_W-1:0] CNT_INIT = {1'b1, {(CNT_W-1){1'b0}}};

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= CNT_INIT;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end

    assign read_sel = count[CNT_W-1];

endmodule

// File: rtl/pp_read_tagger.sv
module pp_read_tagger
    import pp_pkg::*;
(
    input  logic   req,
    input  logic   req_bank,
    input  logic   read_sel,
    input  logic   bank_empty,
    input  logic   bank_last,
    input  event_t bank_head,
    output logic   pop,
    output word_t  word
);
    always_comb begin
        pop  = 1'b0;
        word = WORD_ZERO;
        if (req) begin
            if (req_bank != read_sel) begin
                word = tag_only(ST_BUSY);
            end else if (bank_empty) begin
                word = tag_only(ST_EMPTY);
            end else begin
                pop  = 1'b1;
                word = tag_data(bank_last ? ST_LAST : ST_NORMAL, bank_head);
            end
        end
    end

endmodule

// File: rtl/pp_capture_buffer.sv
module pp_capture_buffer
    import pp_pkg::*;
#(
    parameter int DEPTH = 10,
    parameter int CNT_W = 7
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                tick,
    input  logic                wr_en,
    input  logic [EVENT_W-1:0]  wr_event,
    input  logic                rd_en,
    input  logic                rd_bank,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_word,
    output logic                rd_sel,
    output logic                overflow
);
    localparam int BANKS = 2;

    logic          read_sel;
    logic          write_sel;
    logic          pop_req;
    word_t         next_word;
    word_t         word_q;
    logic          valid_q;
    logic          ovf_q;

    logic [BANKS-1:0] b_full;
    logic [BANKS-1:0] b_empty;
    logic [BANKS-1:0] b_last;
    logic [BANKS-1:0] b_push;
    logic [BANKS-1:0] b_pop;
    event_t           b_head [BANKS];

    pp_role_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .read_sel (read_sel)
    );

    assign write_sel = ~read_sel;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign b_push[b] = wr_en && (write_sel == 1'(b));
        assign b_pop[b]  = pop_req && (read_sel == 1'(b));

        pp_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk   (clk),
            .rst   (rst),
            .push  (b_push[b]),
            .din   (event_t'(wr_event)),
            .pop   (b_pop[b]),
            .head  (b_head[b]),
            .full  (b_full[b]),
            .empty (b_empty[b]),
            .last  (b_last[b])
        );
    end

    pp_read_tagger u_tagger (
        .req        (rd_en),
        .req_bank   (rd_bank),
        .read_sel   (read_sel),
        .bank_empty (b_empty[read_sel]),
        .bank_last  (b_last[read_sel]),
        .bank_head  (b_head[read_sel]),
        .pop        (pop_req),
        .word       (next_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            word_q  <= WORD_ZERO;
            ovf_q   <= 1'b0;
        end else begin
            valid_q <= rd_en;
            word_q  <= next_word;
            if (wr_en && b_full[write_sel]) begin
                ovf_q <= 1'b1;
            end
        end
    end

    assign rd_valid = valid_q;
    assign rd_word  = word_q;
    assign rd_sel   = read_sel;
    assign overflow = ovf_q;

endmodule

// File: rtl/pp_capture_buffer_chk.sv
module pp_capture_buffer_chk (
    input logic        clk,
    input logic        rst,
    input logic        tick,
    input logic        rd_en,
    input logic        rd_bank,
    input logic        rd_valid,
    input logic [22:0] rd_word,
    input logic        rd_sel,
    input logic        overflow
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!rd_valid && !overflow && rd_sel && rd_word == '0));

    // R8
    read_latency_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> (!rd_valid && rd_word == '0));

    // R2
    legal_status_chk: assert property (@(posedge clk) disable iff (rst)
        rd_valid |-> (rd_word[22:20] == 3'b000 || rd_word[22:20] == 3'b001 ||
                      rd_word[22:20] == 3'b010 || rd_word[22:20] == 3'b100));

    // R4
    busy_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rd_bank != rd_sel) |=> (rd_word == {3'b100, 20'd0}));

    // R5
    empty_payload_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_valid && rd_word[22:20] == 3'b010) |-> (rd_word[19:0] == '0));

    // R3
    role_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(rd_sel));

    // R7
    sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

endmodule

bind pp_capture_buffer pp_capture_buffer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .rd_en    (rd_en),
    .rd_bank  (rd_bank),
    .rd_valid (rd_valid),
    .rd_word  (rd_word),
    .rd_sel   (rd_sel),
    .overflow (overflow)
);

// File: tb/test_pp_capture_buffer.sv
module test_pp_capture_buffer;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_event = '0;
    logic        rd_en = 1'b0;
    logic        rd_bank = 1'b0;
    logic        rd_valid;
    logic [22:0] rd_word;
    logic        rd_sel;
    logic        overflow;

    always #2 clk = ~clk;

    pp_capture_buffer i_pp_capture_buffer (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .wr_en    (wr_en),
        .wr_event (wr_event),
        .rd_en    (rd_en),
        .rd_bank  (rd_bank),
        .rd_valid (rd_valid),
        .rd_word  (rd_word),
        .rd_sel   (rd_sel),
        .overflow (overflow)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // Reference model state
    logic [19:0] qa[$];
    logic [19:0] qb[$];
    int          m_cnt = 64;
    bit          m_ovf = 1'b0;
    bit          e_valid = 1'b0;
    logic [22:0] e_word = '0;

    task automatic model_step(input bit r, input bit t, input bit we, input logic [19:0] wd,
                              input bit re, input bit rb);
        bit rs;
        logic [19:0] v;
        if (r) begin
            qa.delete(); qb.delete();
            m_cnt = 64; m_ovf = 0; e_valid = 0; e_word = '0;
            return;
        end
        rs = (m_cnt >= 64);
        e_valid = re;
        e_word  = '0;
        if (re) begin
            if (rb != rs) e_word = {3'b100, 20'd0};
            else if (rs ? qb.size() == 0 : qa.size() == 0) e_word = {3'b010, 20'd0};
            else begin
                v = rs ? qb.pop_front() : qa.pop_front();
                e_word = {((rs ? qb.size() : qa.size()) == 0) ? 3'b001 : 3'b000, v};
            end
        end
        if (we) begin
            if (rs) begin
                if (qa.size() == 10) m_ovf = 1; else qa.push_back(wd);
            end else begin
                if (qb.size() == 10) m_ovf = 1; else qb.push_back(wd);
            end
        end
        if (t) m_cnt = (m_cnt + 1) % 128;
    endtask

    task automatic compare(input string tag);
        bit e_sel;
        e_sel = (m_cnt >= 64);
        n_cmp++;
        if (rd_valid !== e_valid || rd_word !== e_word || rd_sel !== e_sel || overflow !== m_ovf) begin
            n_bad++;
            $display("FAIL %s: actual valid=%b word=%h sel=%b ovf=%b expected valid=%b word=%h sel=%b ovf=%b",
                     tag, rd_valid, rd_word, rd_sel, overflow, e_valid, e_word, e_sel, m_ovf);
        end
    endtask

    task automatic cyc(input bit r, input bit t, input bit we, input logic [19:0] wd,
                       input bit re, input bit rb, input string tag);
        rst = r; tick = t; wr_en = we; wr_event = wd; rd_en = re; rd_bank = rb;
        model_step(r, t, we, wd, re, rb);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic idle(input int n, input bit t, input string tag);
        for (int i = 0; i < n; i++) cyc(0, t, 0, '0, 0, 0, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R8 watchdog: actual run still busy, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state
        cyc(1, 0, 0, '0, 1, 0, "R1");
        cyc(1, 1, 1, 20'h12345, 1, 1, "R1");
        // R9 / R5: fill bank A while reading empty bank B
        cyc(0, 0, 1, 20'h0f8bb, 1, 1, "R5");
        cyc(0, 0, 1, 20'hc1178, 1, 1, "R5");
        cyc(0, 0, 1, 20'h94fea, 0, 0, "R9");
        // R4: read of the write bank
        cyc(0, 0, 0, '0, 1, 0, "R4");
        idle(1, 0, "R8");
        // R3: 64 ticks swap roles
        idle(64, 1, "R3");
        idle(2, 0, "R3");
        // R2 / R6: drain bank A
        cyc(0, 0, 0, '0, 1, 0, "R2");
        cyc(0, 0, 0, '0, 1, 0, "R2");
        cyc(0, 0, 0, '0, 1, 0, "R6");
        cyc(0, 0, 0, '0, 1, 0, "R6");
        cyc(0, 0, 0, '0, 1, 1, "R4");
        // R7: overfill bank B
        for (int i = 0; i < 12; i++) cyc(0, 0, 1, 20'(32'h0e16b + i * 32'h1111), 0, 0, "R7");
        idle(2, 0, "R7");
        // R3 / R9: swap again and drain bank B
        idle(64, 1, "R3");
        for (int i = 0; i < 11; i++) cyc(0, 0, 0, '0, 1, 1, "R6");
        // R9: long random mix
        for (int i = 0; i < 6000; i++)
            cyc(0, ($urandom % 4) == 0, $urandom % 2, 20'($urandom), $urandom % 2, $urandom % 2, "R9");
        // R1: reset in the middle of a run
        cyc(1, 0, 1, 20'h0abcd, 1, 0, "R1");
        cyc(0, 0, 0, '0, 1, 1, "R5");
        idle(2, 0, "R8");
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule